// File: doc/BRIEF.md
# Sleep-Mode Clock Gating Controller

This block lets a small 8-bit microcontroller enter a low-power state by gating its clocks. It drives three gated clocks from one free-running clock: one for the core and its program and data memories, one for the I/O peripherals, and one for the timer. When the core reports that it has executed a sleep instruction, the controller samples a sleep-enable bit and a two-bit mode field. It then stops the clock domains that the chosen mode names.

While asleep, the controller watches the interrupt request lines. It wakes only on a source that the current mode allows, and ignores all other sources. Each gate is a latch that is transparent while the clock is low, followed by an AND gate. An enable can therefore change only during the low phase. A stopped clock resumes on the first rising edge after the edge on which the wake request is seen. No gated output ever carries a shortened high or low phase.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: With `slp_en_i` high and the controller awake, a `slp_req_i` sampled on a rising edge of `clk_i` sets `sleeping_o` high after that edge, and `slp_mode_i` is captured on the same edge. The rising edge that samples the request is the last rising edge of every clock that the mode stops.
- R2: A `slp_req_i` sampled while `slp_en_i` is low has no effect: `sleeping_o` stays low and all three gated clocks keep running.
- R3: Mode codes 2'b00 and 2'b01 select idle. In idle, `core_clk_o` is stopped (held low), and `io_clk_o` and `tmr_clk_o` keep running.
- R4: Mode code 2'b11 selects power-save. In power-save, `core_clk_o` and `io_clk_o` are held low and `tmr_clk_o` keeps running.
- R5: Mode code 2'b10 selects power-down. In power-down, all three gated clocks are held low.
- R6: In idle, any request line wakes the controller: an external interrupt (`irq_ext_i`), the timer (`irq_tmr_i`), or a port/UART request (`irq_io_i`).
- R7: In power-save, only `irq_ext_i` or `irq_tmr_i` wakes the controller. `irq_io_i` is ignored.
- R8: In power-down, only `irq_ext_i` wakes the controller. `irq_tmr_i` and `irq_io_i` are ignored.
- R9: After a wake request is sampled on a rising edge, `sleeping_o` falls after that edge, and every stopped clock resumes on the next rising edge. A gated output rises only while `clk_i` is high and falls only while `clk_i` is low. Every gated high pulse lasts exactly half a clock period.
- R10: While `rst_ni` is low, `sleeping_o` is low and all three gated clocks follow `clk_i`. This holds even when reset is asserted during sleep.
- R11: A `slp_req_i` sampled while asleep does not change the active mode or the set of running clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| slp_req_i | input | 1 | Pulse from the core: sleep instruction executed |
| slp_en_i | input | 1 | Sleep-enable bit of the mode register |
| slp_mode_i | input | 2 | Mode field: 00/01 idle, 10 power-down, 11 power-save |
| irq_ext_i | input | N_EXT | External interrupt requests |
| irq_tmr_i | input | 1 | Timer interrupt request |
| irq_io_i | input | N_IO | Port and UART interrupt requests |
| core_clk_o | output | 1 | Gated clock for the core and memories |
| io_clk_o | output | 1 | Gated clock for the I/O peripherals |
| tmr_clk_o | output | 1 | Gated clock for the timer |
| sleeping_o | output | 1 | High while any mode is active |

## Verification
The hardest situation to reach from the ports is a wake source that the active mode must ignore while that source is asserted for several cycles. Examples are a timer request during power-down and a port request during power-save. A real system running on gated clocks would rarely produce these. The bench drives such requests directly, for several cycles, into each sleeping mode. It also issues a fresh sleep request carrying a different mode while already asleep, then wakes the controller with the one allowed source. Reset is asserted in the middle of power-down to show that the clocks restart at once.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
package sclk_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PSAVE = 2'd2,
    ST_PDOWN = 2'd3
  } slp_state_e;

  localparam int unsigned N_DOM = 3;
  localparam int unsigned DOM_CORE = 0;
  localparam int unsigned DOM_IO   = 1;
  localparam int unsigned DOM_TMR  = 2;

  // Mode field decode: 10 -> power-down, 11 -> power-save, others -> idle
  function automatic slp_state_e mode_to_state(input logic [1:0] mode);
    case (mode)
      2'b10:   return ST_PDOWN;
      2'b11:   return ST_PSAVE;
      default: return ST_IDLE;
    endcase
  endfunction

  // Per-domain clock enable for a given state
  function automatic logic [N_DOM-1:0] dom_enables(input slp_state_e st);
    logic [N_DOM-1:0] en;
    en[DOM_CORE] = (st == ST_AWAKE);
    en[DOM_IO]   = (st == ST_AWAKE) || (st == ST_IDLE);
    en[DOM_TMR]  = (st != ST_PDOWN);
    return en;
  endfunction

endpackage

// File: rtl/sclk_wake_mask.sv
`timescale 1ns/1ps
module sclk_wake_mask
  import sclk_pkg::*;
#(
  parameter int unsigned N_EXT = 2,
  parameter int unsigned N_IO  = 3
) (
  input  slp_state_e        state_i,
  input  logic [N_EXT-1:0]  irq_ext_i,
  input  logic              irq_tmr_i,
  input  logic [N_IO-1:0]   irq_io_i,
  output logic              wake_o
);

  logic ext_any;
  logic io_any;
  logic tmr_ok;
  logic io_ok;

  always_comb begin
    ext_any = |irq_ext_i;
    io_any  = |irq_io_i;
    tmr_ok  = irq_tmr_i && ((state_i == ST_IDLE) || (state_i == ST_PSAVE));
    io_ok   = io_any && (state_i == ST_IDLE);
    wake_o  = (state_i != ST_AWAKE) && (ext_any || tmr_ok || io_ok);
  end

endmodule

// File: rtl/sclk_fsm.sv
`timescale 1ns/1ps
module sclk_fsm
  import sclk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slp_req_i,
  input  logic        slp_en_i,
  input  logic [1:0]  slp_mode_i,
  input  logic        wake_i,
  output slp_state_e  state_o
);

  slp_state_e state_q;
  slp_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d  = state_q;
    state_en = 1'b0;
    if (state_q == ST_AWAKE) begin
      if (slp_req_i && slp_en_i) begin
        state_d  = mode_to_state(slp_mode_i);
        state_en = 1'b1;
      end
    end else if (wake_i) begin
      state_d  = ST_AWAKE;
      state_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/sclk_gate.sv
`timescale 1ns/1ps
module sclk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);

  logic en_lat;

  // transparent during the low phase, holds during the high phase
  always_latch begin
    if (!clk_i) begin
      en_lat = en_i;
    end
  end

  assign gclk_o = clk_i & en_lat;

endmodule

// File: rtl/sleep_clk_ctrl.sv
`timescale 1ns/1ps
module sleep_clk_ctrl
  import sclk_pkg::*;
#(
  parameter int unsigned N_EXT = 2,
  parameter int unsigned N_IO  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slp_req_i,
  input  logic              slp_en_i,
  input  logic [1:0]        slp_mode_i,
  input  logic [N_EXT-1:0]  irq_ext_i,
  input  logic              irq_tmr_i,
  input  logic [N_IO-1:0]   irq_io_i,
  output logic              core_clk_o,
  output logic              io_clk_o,
  output logic              tmr_clk_o,
  output logic              sleeping_o
);

  slp_state_e       state;
  logic             wake;
  logic [N_DOM-1:0] dom_en;
  logic [N_DOM-1:0] dom_clk;

  sclk_wake_mask #(
    .N_EXT (N_EXT),
    .N_IO  (N_IO)
  ) u_wake (
    .state_i   (state),
    .irq_ext_i (irq_ext_i),
    .irq_tmr_i (irq_tmr_i),
    .irq_io_i  (irq_io_i),
    .wake_o    (wake)
  );

  sclk_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slp_req_i  (slp_req_i),
    .slp_en_i   (slp_en_i),
    .slp_mode_i (slp_mode_i),
    .wake_i     (wake),
    .state_o    (state)
  );

  assign dom_en = dom_enables(state);

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    sclk_gate u_gate (
      .clk_i  (clk_i),
      .en_i   (dom_en[g]),
      .gclk_o (dom_clk[g])
    );
  end

  assign core_clk_o = dom_clk[DOM_CORE];
  assign io_clk_o   = dom_clk[DOM_IO];
  assign tmr_clk_o  = dom_clk[DOM_TMR];
  assign sleeping_o = (state != ST_AWAKE);

endmodule

// File: rtl/sleep_clk_ctrl_chk.sv
`timescale 1ns/1ps
module sleep_clk_ctrl_chk #(
  parameter int unsigned N_EXT = 2,
  parameter int unsigned N_IO  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slp_req_i,
  input logic              slp_en_i,
  input logic [1:0]        slp_mode_i,
  input logic [N_EXT-1:0]  irq_ext_i,
  input logic              irq_tmr_i,
  input logic [N_IO-1:0]   irq_io_i,
  input logic              core_clk_o,
  input logic              io_clk_o,
  input logic              tmr_clk_o,
  input logic              sleeping_o
);

  // mode recorded by the checker on each accepted entry
  logic [1:0] cap_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_mode <= 2'b00;
    end else if (!sleeping_o && slp_req_i && slp_en_i) begin
      cap_mode <= slp_mode_i;
    end
  end

  // R1
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleeping_o && slp_req_i && slp_en_i) |=> sleeping_o);

  // R2
  no_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleeping_o && slp_req_i && !slp_en_i) |=> !sleeping_o);

  // R6
  ext_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_o && (|irq_ext_i)) |=> !sleeping_o);

  // R7
  psave_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_o && cap_mode == 2'b11 && !(|irq_ext_i) && !irq_tmr_i) |=> sleeping_o);

  // R8
  pdown_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_o && cap_mode == 2'b10 && !(|irq_ext_i)) |=> sleeping_o);

  // R10
  reset_awake_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !sleeping_o);

  // R9
  always @(posedge core_clk_o) if (rst_ni) core_rise_chk: assert (clk_i);
  // R9
  always @(negedge core_clk_o) if (rst_ni) core_fall_chk: assert (!clk_i);
  // R9
  always @(posedge io_clk_o) if (rst_ni) io_rise_chk: assert (clk_i);
  // R9
  always @(negedge io_clk_o) if (rst_ni) io_fall_chk: assert (!clk_i);
  // R9
  always @(posedge tmr_clk_o) if (rst_ni) tmr_rise_chk: assert (clk_i);
  // R9
  always @(negedge tmr_clk_o) if (rst_ni) tmr_fall_chk: assert (!clk_i);

endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk #(
  .N_EXT (N_EXT),
  .N_IO  (N_IO)
) u_chk (.*);

// File: tb/sleep_clk_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_clk_ctrl_bench;

  localparam int NE = 2;
  localparam int NI = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          en = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [NE-1:0] ext = '0;
  logic          tmr = 1'b0;
  logic [NI-1:0] io = '0;
  logic          core_clk, io_clk, tmr_clk, sleeping;

  int checks = 0;
  int fails  = 0;
  string req_tag = "R10";

  // behavioural model: 0 awake, 1 idle, 2 power-save, 3 power-down
  int m_state = 0;
  int m_prev  = 0;

  always #5 clk = ~clk;

  sleep_clk_ctrl #(.N_EXT(NE), .N_IO(NI)) u_sleep_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .slp_req_i(req), .slp_en_i(en),
    .slp_mode_i(mode), .irq_ext_i(ext), .irq_tmr_i(tmr), .irq_io_i(io),
    .core_clk_o(core_clk), .io_clk_o(io_clk), .tmr_clk_o(tmr_clk),
    .sleeping_o(sleeping)
  );

  function automatic int next_state(int s);
    bit wake;
    if (s == 0) begin
      if (req && en) return (mode == 2'b10) ? 3 : (mode == 2'b11) ? 2 : 1;
      return 0;
    end
    wake = (|ext) || (s != 3 && tmr) || (s == 1 && (|io));
    return wake ? 0 : s;
  endfunction

  // compare every clock: sampled 1 ns after the rising edge, clk high
  always @(posedge clk) begin
    m_prev = m_state;
    if (rst_n) m_state = next_state(m_state);
    else       m_state = 0;
    #1;
    begin
      bit e_core, e_io, e_tmr, e_slp;
      e_core = (m_prev == 0);
      e_io   = (m_prev <= 1);
      e_tmr  = (m_prev != 3);
      e_slp  = (m_state != 0);
      checks++;
      if (core_clk !== e_core || io_clk !== e_io || tmr_clk !== e_tmr || sleeping !== e_slp) begin
        fails++;
        $display("FAIL %s: core/io/tmr/slp actual %b%b%b%b expected %b%b%b%b at %0t",
                 req_tag, core_clk, io_clk, tmr_clk, sleeping,
                 e_core, e_io, e_tmr, e_slp, $time);
      end
    end
  end

  // R9: every gated high pulse lasts half a period
  realtime t_core, t_io, t_tmr;
  always @(posedge core_clk) t_core = $realtime;
  always @(posedge io_clk)   t_io   = $realtime;
  always @(posedge tmr_clk)  t_tmr  = $realtime;
  task automatic width_chk(string nm, realtime t0);
    checks++;
    if ($realtime - t0 != 5.0) begin
      fails++;
      $display("FAIL R9: %s pulse width actual %0t expected 5", nm, $realtime - t0);
    end
  endtask
  always @(negedge core_clk) if (rst_n) width_chk("core", t_core);
  always @(negedge io_clk)   if (rst_n) width_chk("io", t_io);
  always @(negedge tmr_clk)  if (rst_n) width_chk("tmr", t_tmr);

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic enter(bit e, logic [1:0] md);
    en = e; mode = md; req = 1'b1;
    cyc(1);
    req = 1'b0;
  endtask

  initial begin
    // R10 reset state
    req_tag = "R10";
    cyc(3);
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    // awake: interrupts do nothing
    ext = 2'b01; tmr = 1'b1; io = 3'b111; cyc(2);
    ext = '0; tmr = 1'b0; io = '0;
    // R2 enable clear
    req_tag = "R2";
    enter(1'b0, 2'b10); cyc(3);
    // R1 R3 R6 idle, wake by port
    req_tag = "R3";
    enter(1'b1, 2'b00); cyc(3);
    req_tag = "R6";
    io = 3'b100; cyc(1); io = '0; cyc(2);
    // idle via reserved code, wake by timer
    req_tag = "R3";
    enter(1'b1, 2'b01); cyc(2);
    req_tag = "R6";
    tmr = 1'b1; cyc(1); tmr = 1'b0; cyc(2);
    // idle, external wake
    req_tag = "R1";
    enter(1'b1, 2'b00); cyc(1);
    req_tag = "R6";
    ext = 2'b10; cyc(1); ext = '0; cyc(2);
    // R4 R7 power-save: port ignored, R11 new request ignored, timer wake
    req_tag = "R4";
    enter(1'b1, 2'b11); cyc(2);
    req_tag = "R7";
    io = 3'b011; cyc(3); io = '0;
    req_tag = "R11";
    enter(1'b1, 2'b10); cyc(2);
    req_tag = "R9";
    tmr = 1'b1; cyc(1); tmr = 1'b0; cyc(3);
    // power-save, external wake
    req_tag = "R7";
    enter(1'b1, 2'b11); cyc(1);
    ext = 2'b01; cyc(1); ext = '0; cyc(2);
    // R5 R8 power-down: timer and port ignored, external wake
    req_tag = "R5";
    enter(1'b1, 2'b10); cyc(2);
    req_tag = "R8";
    tmr = 1'b1; io = 3'b001; cyc(4); tmr = 1'b0; io = '0;
    ext = 2'b11; cyc(1); ext = '0; cyc(2);
    // request and interrupt in the same cycle
    req_tag = "R1";
    ext = 2'b01; enter(1'b1, 2'b10); ext = '0; cyc(1);
    ext = 2'b01; cyc(1); ext = '0; cyc(2);
    // R10 reset during power-down
    req_tag = "R10";
    enter(1'b1, 2'b10); cyc(2);
    @(negedge clk); rst_n = 1'b0; m_state = 0;
    cyc(3);
    @(negedge clk); rst_n = 1'b1;
    cyc(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule